// File: doc/BRIEF.md
# Scatter-Gather Descriptor Dispatcher

This block is the front end of a scatter-gather DMA engine. Software programs it through one 32-bit memory-mapped slave port. Byte address bit 5 selects between two regions. The lower region is a small control and status window. The upper region is a staging area for an eight-word transfer descriptor. The staged words are only held until software writes the last word, which is the control word. If that write has bit 31 set, the whole descriptor enters a descriptor queue in one clock edge. Any other write leaves the staged words in place and changes nothing else.

Descriptors leave the queue on a valid/ready stream towards the datapath that moves the data. While `dsc_valid` is high, the head descriptor and the valid flag are held until `dsc_ready` is seen high at a clock edge. The datapath may stall for as long as it needs. Only one descriptor is outstanding at a time. The next one is offered only after the datapath returns a completion pulse, which may report error bits and an early-termination flag.

The block also handles the following:
- Software stops, either through control bits or through sticky stop-on-error and stop-on-early states.
- A soft reset that lasts several cycles and that software can watch as a status flag.
- A level interrupt that is gated by a global enable.

Top module: `sgdma_dispatch`

## Requirements
- R1: A write to staging word 7 (byte 0x3C) with bit 31 set places one descriptor at the queue tail in the same edge. Staging word i sits at byte 0x20+4*i. On the stream, word i appears at `dsc_data[32*i+31:32*i]`.
- R2: A write to the control word with bit 31 clear adds nothing to the queue.
- R3: Descriptors leave in commit order. While `dsc_valid` is high and `dsc_ready` is low, `dsc_valid` and `dsc_data` stay stable.
- R4: With DEPTH entries queued, a further commit is dropped. The full flag and the fill level stay unchanged.
- R5: The status register is at byte 0x00. Its bits are:
  - bit 0: busy
  - bit 1: queue empty
  - bit 2: queue full
  - bit 3: response empty, always 1
  - bit 4: response full, always 0
  - bit 5: stopped
  - bit 6: resetting
  - bit 7: stopped on error
  - bit 8: stopped on early termination
  - bit 9: interrupt pending

  The fill register is at byte 0x08 and gives the queue count in both halves. The response fill register at byte 0x0C reads 0.
- R6: Busy is set while the queue is non-empty or a descriptor is outstanding. Once a descriptor is taken, `dsc_valid` stays low until a `cpl_valid` pulse.
- R7: The control register is at byte 0x04. Its bits are:
  - bit 0: stop
  - bit 1: soft reset (reads 0)
  - bit 2: stop on error
  - bit 3: stop on early termination
  - bit 4: global interrupt enable
  - bit 5: stop fetching

  Bit 0 or bit 5 holds `dsc_valid` low and sets status bit 5.
- R8: A completion with a non-zero `cpl_err` while control bit 2 is set sets sticky status bit 7. A completion with `cpl_early` while control bit 3 is set sets sticky status bit 8. While either sticky bit is set, `dsc_valid` is held low. Writing 1 to the bit clears it.
- R9: Status bit 9 is set when a completion arrives while control bit 4 is set and any of these holds:
  - control-word bit 14 of the outstanding descriptor is set;
  - `cpl_err` ANDed with its bits 23:16 is non-zero;
  - `cpl_early` is high and its bit 15 is set.

  `irq` equals status bit 9 AND control bit 4. Writing 1 to status bit 9 clears it.
- R10: Writing control bit 1 flushes the queue, clears the outstanding descriptor, the sticky bits and the sequence register, and raises status bit 6 for RST_CYCLES cycles. Commits during that window are dropped.
- R11: The register at byte 0x10 holds two sequence numbers, each taken from staging word 3 bits 15:0. Bits 31:16 give the sequence of the last accepted commit. Bits 15:0 give the sequence of the last descriptor handed out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_addr | input | 6 | Slave byte address; bit 5 selects staging region |
| s_wr | input | 1 | Slave write strobe |
| s_wdata | input | 32 | Slave write data |
| s_rdata | output | 32 | Slave read data, combinational from s_addr |
| dsc_valid | output | 1 | Descriptor offered to datapath |
| dsc_ready | input | 1 | Datapath accepts descriptor |
| dsc_data | output | 256 | Eight descriptor words, word 0 in the low bits |
| cpl_valid | input | 1 | One-cycle completion of the outstanding descriptor |
| cpl_err | input | 8 | Error bits reported with the completion |
| cpl_early | input | 1 | Completion ended early |
| irq | output | 1 | Interrupt request level |

## Verification
The bench fills the queue to DEPTH and commits once more, then drains it. A design that counted the extra commit or overwrote an entry would show a fill level of DEPTH+1 or a wrong descriptor in the drain order. The bench also checks each cycle of a soft reset. It pushes a commit into the last resetting cycle, where a counter off by one would accept it or release the flag early. It drives error bits that miss the control-word mask, which must not raise an interrupt. Random stalls on `dsc_ready` expose a head that changes or a valid flag that drops before acceptance.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 8;
  localparam int DESC_W     = WORD_W * DESC_WORDS;
  localparam int SEQ_LSB    = 3 * WORD_W;
  localparam int CTL_LSB    = 7 * WORD_W;

  // control-word bit positions decoded by the dispatcher
  localparam int DC_GO       = 31;
  localparam int DC_CPL_IRQ  = 14;
  localparam int DC_ERLY_IRQ = 15;
  localparam int DC_MASK_LSB = 16;

  // register indices inside the CSR window (word address)
  localparam logic [2:0] IDX_STATUS  = 3'd0;
  localparam logic [2:0] IDX_CONTROL = 3'd1;
  localparam logic [2:0] IDX_FILL    = 3'd2;
  localparam logic [2:0] IDX_RESP    = 3'd3;
  localparam logic [2:0] IDX_SEQ     = 3'd4;

  // control register bits
  localparam int CB_STOP       = 0;
  localparam int CB_RESET      = 1;
  localparam int CB_STOP_ERR   = 2;
  localparam int CB_STOP_EARLY = 3;
  localparam int CB_GIE        = 4;
  localparam int CB_STOP_FETCH = 5;

  // write-one-to-clear status bits
  localparam int SB_ERR   = 7;
  localparam int SB_EARLY = 8;
  localparam int SB_IRQ   = 9;

  typedef logic [DESC_W-1:0] desc_t;
endpackage

// File: rtl/sgdma_stage.sv
module sgdma_stage
  import sgdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        widx,
  input  logic [WORD_W-1:0] wdata,
  output logic              commit,
  output desc_t             commit_data
);
  localparam int HELD = DESC_WORDS - 1;
  localparam logic [2:0] LAST_IDX = 3'(HELD);

  logic [WORD_W-1:0] words [HELD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HELD; i++) words[i] <= '0;
    end else if (wr_en && widx != LAST_IDX) begin
      words[widx] <= wdata;
    end
  end

  generate
    for (genvar g = 0; g < HELD; g++) begin : g_pack
      assign commit_data[g*WORD_W +: WORD_W] = words[g];
    end
  endgenerate
  assign commit_data[CTL_LSB +: WORD_W] = wdata;

  assign commit = wr_en && (widx == LAST_IDX) && wdata[DC_GO];

  AST_COMMIT_HAS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && widx == LAST_IDX && !wdata[DC_GO] |-> !commit); // R2
endmodule

// File: rtl/sgdma_fifo.sv
module sgdma_fifo #(
  parameter int WIDTH = 256,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  input  logic             flush,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full,
  output logic [CW-1:0]    count
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop && !flush |=> full && count == $past(count)); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R3
endmodule

// File: rtl/sgdma_csr.sv
module sgdma_csr
  import sgdma_pkg::*;
#(
  parameter int RST_CYCLES = 8,
  parameter int CNT_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic [2:0]        widx,
  input  logic [WORD_W-1:0] wdata,
  input  logic              issue,
  input  logic [9:0]        issue_cfg,
  input  logic [15:0]       issue_seq,
  input  logic              accept,
  input  logic [15:0]       accept_seq,
  input  logic              cpl_valid,
  input  logic [7:0]        cpl_err,
  input  logic              cpl_early,
  input  logic              q_empty,
  input  logic              q_full,
  input  logic [CNT_W-1:0]  q_count,
  output logic              issue_ok,
  output logic              flush,
  output logic              resetting,
  output logic [WORD_W-1:0] rdata,
  output logic              irq
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);
  localparam logic [RC_W-1:0] RC_LOAD = RC_W'(RST_CYCLES);

  logic c_stop, c_stop_err, c_stop_early, c_gie, c_stop_fetch;
  logic st_err, st_early, irq_p, held;
  logic [9:0]      hcfg;
  logic [15:0]     wseq, rseq;
  logic [RC_W-1:0] rcnt;
  logic wr_stat, wr_ctl, soft_go, cpl_take, err_hit, early_hit, irq_hit;
  logic stopped, busy;
  logic [15:0] fill16;

  assign wr_stat   = csr_wr && widx == IDX_STATUS;
  assign wr_ctl    = csr_wr && widx == IDX_CONTROL;
  assign soft_go   = wr_ctl && wdata[CB_RESET];
  assign flush     = soft_go;
  assign resetting = (rcnt != '0);
  assign cpl_take  = cpl_valid && held && !resetting;
  assign err_hit   = cpl_take && c_stop_err && (cpl_err != 8'd0);
  assign early_hit = cpl_take && c_stop_early && cpl_early;
  assign irq_hit   = cpl_take && c_gie &&
                     (hcfg[0] || (hcfg[1] && cpl_early) || ((cpl_err & hcfg[9:2]) != 8'd0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {c_stop, c_stop_err, c_stop_early, c_gie, c_stop_fetch} <= '0;
      {st_err, st_early, irq_p, held} <= '0;
      hcfg <= '0;
      wseq <= '0;
      rseq <= '0;
      rcnt <= '0;
    end else begin
      if (wr_ctl) begin
        c_stop       <= wdata[CB_STOP];
        c_stop_err   <= wdata[CB_STOP_ERR];
        c_stop_early <= wdata[CB_STOP_EARLY];
        c_gie        <= wdata[CB_GIE];
        c_stop_fetch <= wdata[CB_STOP_FETCH];
      end
      if (soft_go)        rcnt <= RC_LOAD;
      else if (resetting) rcnt <= rcnt - 1'b1;

      if (soft_go) begin
        {st_err, st_early, irq_p, held} <= '0;
        wseq <= '0;
        rseq <= '0;
      end else begin
        if (issue) begin
          held <= 1'b1;
          hcfg <= issue_cfg;
          rseq <= issue_seq;
        end else if (cpl_take) begin
          held <= 1'b0;
        end
        if (accept) wseq <= accept_seq;
        if (err_hit)                      st_err   <= 1'b1;
        else if (wr_stat && wdata[SB_ERR])   st_err   <= 1'b0;
        if (early_hit)                    st_early <= 1'b1;
        else if (wr_stat && wdata[SB_EARLY]) st_early <= 1'b0;
        if (irq_hit)                      irq_p    <= 1'b1;
        else if (wr_stat && wdata[SB_IRQ])   irq_p    <= 1'b0;
      end
    end
  end

  assign stopped  = c_stop || c_stop_fetch || st_err || st_early;
  assign busy     = !q_empty || held;
  assign issue_ok = !stopped && !resetting && !held;
  assign irq      = irq_p && c_gie;
  assign fill16   = 16'(q_count);

  always_comb begin
    case (widx)
      IDX_STATUS:  rdata = {22'd0, irq_p, st_early, st_err, resetting, stopped,
                            1'b0, 1'b1, q_full, q_empty, busy};
      IDX_CONTROL: rdata = {26'd0, c_stop_fetch, c_gie, c_stop_early, c_stop_err,
                            1'b0, c_stop};
      IDX_FILL:    rdata = {fill16, fill16};
      IDX_RESP:    rdata = '0;
      IDX_SEQ:     rdata = {wseq, rseq};
      default:     rdata = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = &{1'b0, wdata[31:10], wdata[6]};

  AST_RESET_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    soft_go |=> resetting); // R10
  AST_RESET_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    resetting && !soft_go |=> rcnt == RC_W'($past(rcnt) - 1'b1)); // R10
  AST_STOP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_err) |-> $past(cpl_valid)); // R8
  AST_IRQ_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat && wdata[SB_IRQ] && !irq_hit |=> !irq); // R9
  AST_SINGLE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> !issue); // R6
endmodule

// File: rtl/sgdma_dispatch.sv
module sgdma_dispatch
  import sgdma_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        s_addr,
  input  logic              s_wr,
  input  logic [WORD_W-1:0] s_wdata,
  output logic [WORD_W-1:0] s_rdata,
  output logic              dsc_valid,
  input  logic              dsc_ready,
  output logic [DESC_W-1:0] dsc_data,
  input  logic              cpl_valid,
  input  logic [7:0]        cpl_err,
  input  logic              cpl_early,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic        stage_sel, stage_wr, csr_wr;
  logic [2:0]  widx;
  logic        commit, push_ok, accept, pop;
  desc_t       commit_data, head;
  logic        q_empty, q_full, issue_ok, flush, resetting;
  logic [CNT_W-1:0]  q_count;
  logic [WORD_W-1:0] csr_rdata;

  assign stage_sel = s_addr[5];
  assign widx      = s_addr[4:2];
  assign stage_wr  = s_wr && stage_sel;
  assign csr_wr    = s_wr && !stage_sel;

  sgdma_stage u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(stage_wr), .widx(widx), .wdata(s_wdata),
    .commit(commit), .commit_data(commit_data)
  );

  assign push_ok = commit && !resetting;
  assign accept  = push_ok && !q_full;
  assign pop     = dsc_valid && dsc_ready;

  sgdma_fifo #(.WIDTH(DESC_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_ok), .din(commit_data), .pop(pop),
    .flush(flush), .dout(head), .empty(q_empty), .full(q_full), .count(q_count)
  );

  sgdma_csr #(.RST_CYCLES(RST_CYCLES), .CNT_W(CNT_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .widx(widx), .wdata(s_wdata),
    .issue(pop),
    .issue_cfg({head[CTL_LSB+DC_MASK_LSB +: 8], head[CTL_LSB+DC_ERLY_IRQ],
                head[CTL_LSB+DC_CPL_IRQ]}),
    .issue_seq(head[SEQ_LSB +: 16]),
    .accept(accept), .accept_seq(commit_data[SEQ_LSB +: 16]),
    .cpl_valid(cpl_valid), .cpl_err(cpl_err), .cpl_early(cpl_early),
    .q_empty(q_empty), .q_full(q_full), .q_count(q_count),
    .issue_ok(issue_ok), .flush(flush), .resetting(resetting),
    .rdata(csr_rdata), .irq(irq)
  );

  assign dsc_valid = !q_empty && issue_ok;
  assign dsc_data  = head;
  assign s_rdata   = stage_sel ? '0 : csr_rdata;

  logic unused_addr;
  assign unused_addr = &{1'b0, s_addr[1:0]};

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_valid && !dsc_ready && !csr_wr |=> dsc_valid && $stable(dsc_data)); // R3
  AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !pop |=> !q_empty); // R1
endmodule

// File: tb/tb_sgdma_dispatch.sv
module tb_sgdma_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int RST_CYCLES = 8;
  localparam logic [31:0] ST_BUSY = 32'h1, ST_EMPTY = 32'h2, ST_FULL = 32'h4,
    ST_RESPE = 32'h8, ST_STOP = 32'h20, ST_RST = 32'h40, ST_ERR = 32'h80,
    ST_EARLY = 32'h100, ST_IRQ = 32'h200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] s_addr = '0;
  logic s_wr = 1'b0;
  logic [31:0] s_wdata = '0, s_rdata;
  logic dsc_valid, dsc_ready = 1'b0;
  logic [255:0] dsc_data;
  logic cpl_valid = 1'b0, cpl_early = 1'b0, irq;
  logic [7:0] cpl_err = '0;
  int checks = 0, errors = 0;
  bit mon_en = 1'b0;
  logic [255:0] exp_q [$];

  sgdma_dispatch #(.DEPTH(DEPTH), .RST_CYCLES(RST_CYCLES)) dut (
    .clk(clk), .rst_n(rst_n), .s_addr(s_addr), .s_wr(s_wr), .s_wdata(s_wdata),
    .s_rdata(s_rdata), .dsc_valid(dsc_valid), .dsc_ready(dsc_ready),
    .dsc_data(dsc_data), .cpl_valid(cpl_valid), .cpl_err(cpl_err),
    .cpl_early(cpl_early), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] mk_desc(input int seq, input logic [31:0] ctl);
    logic [255:0] d;
    for (int i = 0; i < 7; i++) d[i*32 +: 32] = 32'hA500_0000 ^ (seq << 8) ^ i;
    d[96 +: 32] = {16'h0, 16'(seq)};
    d[224 +: 32] = ctl;
    return d;
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    s_addr = a; s_wdata = d; s_wr = 1'b1;
    @(posedge clk); #1;
    s_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    s_addr = a; #1;
    d = s_rdata;
  endtask

  task automatic commit(input logic [255:0] d);
    for (int i = 0; i < 8; i++) wr(6'(32 + 4*i), d[i*32 +: 32]);
  endtask

  task automatic take(output logic [255:0] d);
    int n = 0;
    dsc_ready = 1'b1;
    while (!dsc_valid && n < 1000) begin @(posedge clk); #1; n++; end
    d = dsc_data;
    @(posedge clk); #1;
    dsc_ready = 1'b0;
  endtask

  task automatic complete(input logic [7:0] e, input logic early);
    cpl_valid = 1'b1; cpl_err = e; cpl_early = early;
    @(posedge clk); #1;
    cpl_valid = 1'b0; cpl_err = '0; cpl_early = 1'b0;
  endtask

  task automatic chk_reg(input logic [5:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(v == exp, tag, v, exp);
  endtask

  // R3: hold check while stalled
  logic pv = 1'b0, pr = 1'b0;
  logic [255:0] pd = '0;
  always @(negedge clk) begin
    if (mon_en && pv && !pr)
      chk(dsc_valid && dsc_data == pd, "R3 stalled head changed", dsc_data, pd);
    pv = dsc_valid; pr = dsc_ready; pd = dsc_data;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [255:0] d, got, extra;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // reset state
    chk_reg(6'h00, ST_EMPTY | ST_RESPE, "R5 reset status");
    chk_reg(6'h08, 32'h0, "R5 reset fill");
    chk_reg(6'h0C, 32'h0, "R5 resp fill");
    chk(!dsc_valid && !irq, "R6 reset outputs", {dsc_valid, irq}, 0);

    // R2: control word without go
    commit(mk_desc(1, 32'h0000_4000));
    chk_reg(6'h00, ST_EMPTY | ST_RESPE, "R2 no go no push");

    // R1: commit
    d = mk_desc(16'h0011, 32'h8000_4000);
    commit(d);
    chk_reg(6'h00, ST_BUSY | ST_RESPE, "R1 status after commit");
    chk_reg(6'h08, 32'h0001_0001, "R5 fill one");
    chk(dsc_valid && dsc_data == d, "R1 word layout", dsc_data, d);
    chk_reg(6'h10, 32'h0011_0000, "R11 write seq");

    // R6: one outstanding
    commit(mk_desc(16'h0022, 32'h8001_0000));
    take(got);
    chk(got == d, "R1 taken data", got, d);
    chk(!dsc_valid, "R6 held blocks next", dsc_valid, 0);
    chk_reg(6'h00, ST_BUSY | ST_RESPE, "R6 busy held");
    chk_reg(6'h10, 32'h0022_0011, "R11 read seq");

    // R9: interrupts
    wr(6'h04, 32'h10);
    complete(8'h00, 1'b0);
    chk(irq, "R9 completion irq", irq, 1);
    chk_reg(6'h00, ST_IRQ | ST_BUSY | ST_RESPE, "R9 status bit9");
    wr(6'h00, ST_IRQ);
    chk(!irq, "R9 w1c", irq, 0);
    take(got);
    complete(8'h02, 1'b0);
    chk(!irq, "R9 mask miss", irq, 0);
    commit(mk_desc(3, 32'h8001_0000));
    take(got);
    complete(8'h01, 1'b0);
    chk(irq, "R9 mask hit", irq, 1);
    wr(6'h00, ST_IRQ);
    commit(mk_desc(4, 32'h8000_8000));
    take(got);
    complete(8'h00, 1'b1);
    chk(irq, "R9 early irq", irq, 1);
    wr(6'h00, ST_IRQ);
    wr(6'h04, 32'h0);
    commit(mk_desc(5, 32'h8000_4000));
    take(got);
    complete(8'h00, 1'b0);
    chk_reg(6'h00, ST_EMPTY | ST_RESPE, "R9 gie off no sticky");

    // R8: stop on error / early
    wr(6'h04, 32'h4);
    commit(mk_desc(6, 32'h8000_0000));
    take(got);
    complete(8'h80, 1'b0);
    chk_reg(6'h00, ST_ERR | ST_STOP | ST_EMPTY | ST_RESPE, "R8 stopped on error");
    d = mk_desc(7, 32'h8000_0000);
    commit(d);
    chk(!dsc_valid, "R8 error stop holds", dsc_valid, 0);
    wr(6'h00, ST_ERR);
    chk(dsc_valid && dsc_data == d, "R8 resume after w1c", dsc_data, d);
    take(got);
    complete(8'h00, 1'b0);
    wr(6'h04, 32'h8);
    commit(mk_desc(8, 32'h8000_0000));
    take(got);
    complete(8'h00, 1'b1);
    chk_reg(6'h00, ST_EARLY | ST_STOP | ST_EMPTY | ST_RESPE, "R8 stopped on early");
    commit(mk_desc(9, 32'h8000_0000));
    chk(!dsc_valid, "R8 early stop holds", dsc_valid, 0);
    wr(6'h00, ST_EARLY);
    chk(dsc_valid, "R8 early resume", dsc_valid, 1);
    take(got);
    complete(8'h00, 1'b0);

    // R7: stop and stop-fetch
    wr(6'h04, 32'h1);
    commit(mk_desc(10, 32'h8000_0000));
    chk(!dsc_valid, "R7 stop bit", dsc_valid, 0);
    chk_reg(6'h00, ST_STOP | ST_BUSY | ST_RESPE, "R7 stopped status");
    wr(6'h04, 32'h20);
    chk(!dsc_valid, "R7 stop fetch", dsc_valid, 0);
    chk_reg(6'h04, 32'h20, "R7 control readback");
    wr(6'h04, 32'h0);
    chk(dsc_valid, "R7 released", dsc_valid, 1);
    take(got);
    complete(8'h00, 1'b0);

    // R4: overflow drop
    wr(6'h04, 32'h1);
    for (int i = 0; i < DEPTH; i++) begin
      d = mk_desc(100 + i, 32'h8000_0000);
      exp_q.push_back(d);
      commit(d);
    end
    chk_reg(6'h00, ST_BUSY | ST_FULL | ST_STOP | ST_RESPE, "R4 full status");
    chk_reg(6'h08, {16'(DEPTH), 16'(DEPTH)}, "R5 fill full");
    extra = mk_desc(200, 32'h8000_0000);
    commit(extra);
    chk_reg(6'h08, {16'(DEPTH), 16'(DEPTH)}, "R4 drop keeps fill");
    chk_reg(6'h00, ST_BUSY | ST_FULL | ST_STOP | ST_RESPE, "R4 drop keeps full");
    wr(6'h04, 32'h0);
    for (int i = 0; i < DEPTH; i++) begin
      d = exp_q.pop_front();
      take(got);
      chk(got == d, "R3 drain order", got, d);
      complete(8'h00, 1'b0);
    end
    chk_reg(6'h00, ST_EMPTY | ST_RESPE, "R4 extra not present");

    // R10: soft reset
    wr(6'h04, 32'h10);
    commit(mk_desc(11, 32'h8000_4000));
    take(got);
    complete(8'h00, 1'b0);
    chk(irq, "R10 irq before reset", irq, 1);
    wr(6'h04, 32'h1);
    for (int i = 0; i < 3; i++) commit(mk_desc(20 + i, 32'h8000_0000));
    chk_reg(6'h08, 32'h0003_0003, "R10 fill before reset");
    wr(6'h04, 32'h2);
    chk_reg(6'h00, ST_RST | ST_EMPTY | ST_RESPE, "R10 resetting and flushed");
    d = mk_desc(30, 32'h8000_0000);
    for (int i = 0; i < 7; i++) wr(6'(32 + 4*i), d[i*32 +: 32]);
    chk_reg(6'h00, ST_RST | ST_EMPTY | ST_RESPE, "R10 still resetting last cycle");
    wr(6'h3C, d[255:224]);
    chk_reg(6'h00, ST_EMPTY | ST_RESPE, "R10 done, commit dropped");
    chk_reg(6'h10, 32'h0, "R10 seq cleared");
    chk(!irq, "R10 irq cleared", irq, 0);

    // R3: random traffic with random stalls
    exp_q.delete();
    mon_en = 1'b1;
    fork
      begin : writer
        for (int n = 0; n < 60; n++) begin
          logic [31:0] f;
          logic [255:0] r;
          rd(6'h08, f);
          while (f[15:0] >= 16'(DEPTH)) begin @(posedge clk); #1; rd(6'h08, f); end
          for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
          r[255] = 1'b1;
          exp_q.push_back(r);
          @(posedge clk); #1;
          commit(r);
        end
      end
      begin : popper
        int got_n = 0;
        while (got_n < 60) begin
          bit hs;
          logic [255:0] e;
          dsc_ready = 1'($urandom % 2);
          #1;
          hs = dsc_valid && dsc_ready;
          if (hs) begin
            e = exp_q.pop_front();
            chk(dsc_data == e, "R3 random order", dsc_data, e);
            got_n++;
          end
          @(posedge clk); #1;
          if (hs) begin
            dsc_ready = 1'b0;
            repeat ($urandom % 3) @(posedge clk);
            #1;
            complete(8'($urandom), 1'b0);
          end
        end
        dsc_ready = 1'b0;
      end
    join
    mon_en = 1'b0;
    chk_reg(6'h00, ST_EMPTY | ST_RESPE, "R3 idle after random");
    chk(!irq, "R9 no irq with gie off", irq, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule